// File: doc/BRIEF.md
# SPI EEPROM Byte Read Sequencer

This block is the master end of a four-wire SPI link to a serial EEPROM. It performs one random-address byte read. The host gives a single-cycle start pulse together with a 16-bit address. The block then pulls chip select low and sends the read command code followed by the address. It keeps the serial clock running long enough to collect one data byte from the memory. Finally it raises chip select again and returns the byte along with a one-cycle completion pulse.

Every serial clock edge, every change of the outgoing bit and every sample of the incoming bit falls on a quarter-period grid. A programmable divider builds that grid from the system clock. A serial clock period is four quarter ticks. The clock rises at the start of a period and falls at its midpoint. The outgoing bit moves, and the incoming bit is sampled, at the three-quarter point. Any start pulse that arrives while a read is running is ignored.

Top module: `eeprom_rd_seq`

## Requirements
- R1: After reset, and at all times when no read is running, chip select is high (inactive), the serial clock is low, and busy and done are both low.
- R2: On the rising serial clock edges, the outgoing line first carries the command code 8'h03 and then the 16-bit address latched at start. Both are sent most significant bit first, so 24 bits precede the data phase.
- R3: A start pulse accepted while idle pulls chip select low on the same edge and puts the first command bit on the outgoing line. The first serial clock rise comes exactly one quarter period (QTR_CYCLES system cycles) after chip select falls.
- R4: Each serial clock high phase lasts exactly 2*QTR_CYCLES system cycles. Each period lasts 4*QTR_CYCLES cycles. Exactly 32 rising edges occur per read.
- R5: The outgoing line changes only at the three-quarter point of a period. It never changes while the serial clock is high.
- R6: The incoming line is sampled at the three-quarter point of periods 23 through 30, counting the first rise as period 0. These samples supply data bits 7 down to 0, and the byte on data_o equals the byte the memory sent.
- R7: The outgoing line is low on every rising edge after the 24th.
- R8: Chip select rises at the three-quarter point of period 31, which is 128*QTR_CYCLES system cycles after it fell. Done is high for exactly that one cycle.
- R9: Busy is high from the cycle after the accepted start up to and including the done cycle. A start pulse during that window changes neither the address sent nor the number of done pulses.
- R10: data_o is stable during the done cycle and holds the captured byte until the next read captures new data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle request to begin a read |
| addr_i | input | ADDR_W | Memory address, latched with an accepted start |
| so_i | input | 1 | Serial data from the memory |
| cs_n_o | output | 1 | Active-low chip select |
| sck_o | output | 1 | Serial clock, idles low |
| si_o | output | 1 | Serial data to the memory |
| busy_o | output | 1 | A read is in progress |
| done_o | output | 1 | One-cycle pulse when the byte is ready |
| data_o | output | DATA_W | Byte returned by the last read |

## Verification
The bound checker watches several rules on every cycle. Chip select and the serial clock must rest in their idle state whenever the block is not busy. Each high phase of the serial clock must last exactly half a period. The outgoing bit must hold still while the clock is high. Done must be a single cycle, it must line up with the chip select rise, and it must present stable data. Busy may only begin after a start pulse. Other properties only the bench's memory responder can show: the exact bits on the wire, the quarter-period lead of the first rise, the count of 32 rising edges, the total transaction length, that the data bits are captured in the right order, and that a start pulse issued mid-read truly leaves the address sent unchanged.

// File: rtl/eeprom_rd_pkg.sv
package eeprom_rd_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_SETUP,
      ST_SHIFT_CMD,
      ST_SHIFT_DATA,
      ST_FINISH
   } seq_state_t;

   // last quarter point passed inside the current serial clock period
   typedef enum logic [1:0] {
      PH_RISE,
      PH_QTR,
      PH_HALF,
      PH_3QTR
   } quarter_t;

endpackage

// File: rtl/eeprom_qtick.sv
module eeprom_qtick #(
   parameter int QTR_CYCLES = 250
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run_i,
   output logic tick_o
);

   generate
      if (QTR_CYCLES == 1) begin : g_direct
         // one system cycle per quarter: every running cycle is a tick
         assign tick_o = run_i;
      end else begin : g_count
         localparam int CW = $clog2(QTR_CYCLES);
         localparam logic [CW-1:0] CMAX = CW'(QTR_CYCLES - 1);

         logic [CW-1:0] cnt_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt_q <= '0;
            end else if (!run_i) begin
               cnt_q <= '0;
            end else if (cnt_q == CMAX) begin
               cnt_q <= '0;
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end

         assign tick_o = run_i && (cnt_q == CMAX);
      end
   endgenerate

endmodule

// File: rtl/eeprom_cmd_shift.sv
module eeprom_cmd_shift #(
   parameter int OP_W = 8,
   parameter int ADDR_W = 16,
   parameter logic [OP_W-1:0] READ_OP = 8'h03
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              shift_i,
   output logic              si_o
);

   localparam int CMD_W = OP_W + ADDR_W;

   logic [CMD_W-1:0] sr_q;

   // zero fill: once the command has left, the line rests low
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sr_q <= '0;
      end else if (load_i) begin
         sr_q <= {READ_OP, addr_i};
      end else if (shift_i) begin
         sr_q <= {sr_q[CMD_W-2:0], 1'b0};
      end
   end

   assign si_o = sr_q[CMD_W-1];

endmodule

// File: rtl/eeprom_rx_shift.sv
module eeprom_rx_shift #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sample_i,
   input  logic              so_i,
   output logic [DATA_W-1:0] data_o
);

   logic [DATA_W-1:0] rx_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_q <= '0;
      end else if (sample_i) begin
         rx_q <= {rx_q[DATA_W-2:0], so_i};
      end
   end

   assign data_o = rx_q;

endmodule

// File: rtl/eeprom_rd_seq.sv
module eeprom_rd_seq
   import eeprom_rd_pkg::*;
#(
   parameter int QTR_CYCLES = 250,
   parameter int OP_W = 8,
   parameter int ADDR_W = 16,
   parameter int DATA_W = 8,
   parameter logic [OP_W-1:0] READ_OP = 8'h03
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              so_i,
   output logic              cs_n_o,
   output logic              sck_o,
   output logic              si_o,
   output logic              busy_o,
   output logic              done_o,
   output logic [DATA_W-1:0] data_o
);

   localparam int CMD_W      = OP_W + ADDR_W;
   localparam int TOTAL_BITS = CMD_W + DATA_W;
   localparam int BIT_W      = $clog2(TOTAL_BITS);
   localparam logic [BIT_W-1:0] LAST_CMD     = BIT_W'(CMD_W - 1);
   localparam logic [BIT_W-1:0] FIRST_SAMPLE = BIT_W'(CMD_W - 1);
   localparam logic [BIT_W-1:0] LAST_SAMPLE  = BIT_W'(TOTAL_BITS - 2);
   localparam logic [BIT_W-1:0] LAST_IDX     = BIT_W'(TOTAL_BITS - 1);

   generate
      if (QTR_CYCLES < 1) begin : g_bad_qtr
         $error("eeprom_rd_seq: QTR_CYCLES must be at least 1");
      end
      if (DATA_W < 2) begin : g_bad_data
         $error("eeprom_rd_seq: DATA_W must be at least 2");
      end
      if (OP_W + ADDR_W < 2) begin : g_bad_cmd
         $error("eeprom_rd_seq: command must be at least 2 bits");
      end
   endgenerate

   seq_state_t        state_q;
   quarter_t          qph_q;
   logic [BIT_W-1:0]  bitc_q;
   logic              sck_q;
   logic              cs_n_q;

   logic              tick;
   logic              running;
   logic              shifting;
   logic              load;
   logic              at_3q;
   logic              sample;

   assign shifting = (state_q == ST_SHIFT_CMD) || (state_q == ST_SHIFT_DATA);
   assign running  = (state_q == ST_SETUP) || shifting;
   assign load     = (state_q == ST_IDLE) && start_i;
   assign at_3q    = tick && shifting && (qph_q == PH_HALF);
   assign sample   = at_3q && (bitc_q >= FIRST_SAMPLE) && (bitc_q <= LAST_SAMPLE);

   eeprom_qtick #(
      .QTR_CYCLES(QTR_CYCLES)
   ) u_qtick (
      .clk    (clk),
      .rst_n  (rst_n),
      .run_i  (running),
      .tick_o (tick)
   );

   eeprom_cmd_shift #(
      .OP_W   (OP_W),
      .ADDR_W (ADDR_W),
      .READ_OP(READ_OP)
   ) u_cmd (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (load),
      .addr_i (addr_i),
      .shift_i(at_3q),
      .si_o   (si_o)
   );

   eeprom_rx_shift #(
      .DATA_W(DATA_W)
   ) u_rx (
      .clk     (clk),
      .rst_n   (rst_n),
      .sample_i(sample),
      .so_i    (so_i),
      .data_o  (data_o)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         qph_q   <= PH_RISE;
         bitc_q  <= '0;
         sck_q   <= 1'b0;
         cs_n_q  <= 1'b1;
      end else begin
         case (state_q)
            ST_IDLE: begin
               if (start_i) begin
                  state_q <= ST_SETUP;
                  cs_n_q  <= 1'b0;
               end
            end
            ST_SETUP: begin
               // one quarter of setup time on the first bit
               if (tick) begin
                  state_q <= ST_SHIFT_CMD;
                  sck_q   <= 1'b1;
                  qph_q   <= PH_RISE;
                  bitc_q  <= '0;
               end
            end
            ST_SHIFT_CMD, ST_SHIFT_DATA: begin
               if (tick) begin
                  case (qph_q)
                     PH_RISE: qph_q <= PH_QTR;
                     PH_QTR: begin
                        qph_q <= PH_HALF;
                        sck_q <= 1'b0;
                     end
                     PH_HALF: begin
                        qph_q <= PH_3QTR;
                        if (bitc_q == LAST_CMD) begin
                           state_q <= ST_SHIFT_DATA;
                        end
                        if (bitc_q == LAST_IDX) begin
                           state_q <= ST_FINISH;
                           cs_n_q  <= 1'b1;
                        end
                     end
                     PH_3QTR: begin
                        qph_q  <= PH_RISE;
                        sck_q  <= 1'b1;
                        bitc_q <= bitc_q + 1'b1;
                     end
                     default: qph_q <= PH_RISE;
                  endcase
               end
            end
            ST_FINISH: state_q <= ST_IDLE;
            default:   state_q <= ST_IDLE;
         endcase
      end
   end

   assign cs_n_o = cs_n_q;
   assign sck_o  = sck_q;
   assign busy_o = (state_q != ST_IDLE);
   assign done_o = (state_q == ST_FINISH);

endmodule

// File: rtl/eeprom_rd_seq_chk.sv
module eeprom_rd_seq_chk #(
   parameter int QTR_CYCLES = 250,
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start_i,
   input logic              cs_n_o,
   input logic              sck_o,
   input logic              si_o,
   input logic              busy_o,
   input logic              done_o,
   input logic [DATA_W-1:0] data_o
);

   // length of the current serial clock high phase, in system cycles
   int unsigned hi_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_cnt <= 0;
      end else if (sck_o) begin
         hi_cnt <= hi_cnt + 1;
      end else begin
         hi_cnt <= 0;
      end
   end

   a_r1_idle_lines: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> (cs_n_o && !sck_o));

   a_r3_cs_falls_on_start: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cs_n_o) |-> ($past(start_i) && $rose(busy_o)));

   a_r4_high_phase_width: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sck_o) |-> (hi_cnt == 2 * QTR_CYCLES));

   a_r5_si_still_while_high: assert property (@(posedge clk) disable iff (!rst_n)
      sck_o |-> $stable(si_o));

   a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   a_r8_cs_rise_with_done: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cs_n_o) |-> done_o);

   a_r9_busy_covers_done: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> busy_o);

   a_r9_busy_needs_start: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_o) |-> $past(start_i));

   a_r10_data_steady_at_done: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> $stable(data_o));

endmodule

bind eeprom_rd_seq eeprom_rd_seq_chk #(
   .QTR_CYCLES(QTR_CYCLES),
   .DATA_W    (DATA_W)
) u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .start_i(start_i),
   .cs_n_o (cs_n_o),
   .sck_o  (sck_o),
   .si_o   (si_o),
   .busy_o (busy_o),
   .done_o (done_o),
   .data_o (data_o)
);

// File: tb/eeprom_rd_seq_test.sv
module eeprom_rd_seq_test;

   localparam int Q = 2;
   localparam longint TCLK = 4;
   localparam int NVEC = 8;
   // {address, byte the memory returns}
   localparam logic [23:0] VEC [0:NVEC-1] = '{
      {16'h0000, 8'hA5}, {16'hFFFF, 8'h3C}, {16'h1234, 8'h00}, {16'h8001, 8'hFF},
      {16'h5555, 8'h81}, {16'hAAAA, 8'h7E}, {16'h0F0F, 8'h01}, {16'hF0F0, 8'h80}
   };

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic        rst_n;
   logic        start;
   logic [15:0] addr;
   logic        so;
   logic        cs_n, sck, si, busy, done;
   logic [7:0]  dout;

   int nchk = 0;
   int nerr = 0;

   eeprom_rd_seq #(.QTR_CYCLES(Q)) uut (
      .clk    (clk),
      .rst_n  (rst_n),
      .start_i(start),
      .addr_i (addr),
      .so_i   (so),
      .cs_n_o (cs_n),
      .sck_o  (sck),
      .si_o   (si),
      .busy_o (busy),
      .done_o (done),
      .data_o (dout)
   );

   // memory responder
   int          nrise;
   logic [23:0] shin;
   logic [7:0]  resp_byte;
   int          si_bad, si_glitch;
   logic        si_at_rise;
   longint      t_cs_fall, t_cs_rise, t_first_rise, t_first_fall;

   initial begin
      so = 1'b0; resp_byte = 8'h00; nrise = 0; shin = '0;
      si_bad = 0; si_glitch = 0; si_at_rise = 1'b0;
      t_cs_fall = 0; t_cs_rise = 0; t_first_rise = 0; t_first_fall = 0;
   end

   always @(negedge cs_n) begin
      nrise = 0; shin = '0; si_bad = 0; si_glitch = 0;
      t_cs_fall = longint'($time);
   end

   always @(posedge cs_n) t_cs_rise = longint'($time);

   always @(posedge sck) begin
      if (!cs_n) begin
         if (nrise == 0) t_first_rise = longint'($time);
         if (nrise < 24) shin = {shin[22:0], si};
         else if (si !== 1'b0) si_bad++;
         si_at_rise = si;
         nrise++;
      end
   end

   always @(negedge sck) begin
      if (!cs_n) begin
         if (nrise == 1) t_first_fall = longint'($time);
         if (si !== si_at_rise) si_glitch++;
         if (nrise >= 24 && nrise <= 31) so = resp_byte[31 - nrise];
      end
   end

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      nchk++;
      if (!ok) begin
         nerr++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // one read; a second start with another address is issued after extra_at cycles (0 = none)
   task automatic run_read(input logic [15:0] a, input logic [7:0] b, input int extra_at,
                           output int done_at, output int done_cnt, output int busy_gaps);
      resp_byte = b;
      done_at = 0; done_cnt = 0; busy_gaps = 0;
      @(negedge clk);
      addr = a; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      for (int k = 1; k < 2000 && done_at == 0; k++) begin
         if (k > 1) @(negedge clk);
         if (extra_at != 0 && k == extra_at) begin
            start = 1'b1; addr = ~a;
         end else begin
            start = 1'b0;
         end
         if (!busy) busy_gaps++;
         if (done) begin
            done_at = k; done_cnt++;
         end
      end
      start = 1'b0;
      for (int k = 0; k < 4; k++) begin
         @(negedge clk);
         if (done) done_cnt++;
      end
   endtask

   initial begin
      int d_at, d_cnt, gaps;
      logic [7:0] held;
      rst_n = 1'b0; start = 1'b0; addr = '0;
      repeat (3) @(negedge clk);
      // R1: reset state
      chk(cs_n === 1'b1, "R1 cs_n in reset", cs_n, 1);
      chk(sck === 1'b0 && busy === 1'b0 && done === 1'b0, "R1 sck/busy/done in reset",
          {sck, busy, done}, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk(cs_n === 1'b1 && sck === 1'b0 && busy === 1'b0, "R1 idle after reset",
          {cs_n, sck, busy}, 3'b100);

      // table of reads
      for (int i = 0; i < NVEC; i++) begin
         run_read(VEC[i][23:8], VEC[i][7:0], 0, d_at, d_cnt, gaps);
         chk(shin == {8'h03, VEC[i][23:8]}, "R2 opcode and address on wire", shin,
             {8'h03, VEC[i][23:8]});
         chk(t_first_rise - t_cs_fall == Q * TCLK, "R3 setup quarter before first rise",
             t_first_rise - t_cs_fall, Q * TCLK);
         chk(t_first_fall - t_first_rise == 2 * Q * TCLK, "R4 high phase width",
             t_first_fall - t_first_rise, 2 * Q * TCLK);
         chk(nrise == 32, "R4 rising edge count", nrise, 32);
         chk(si_glitch == 0, "R5 si moved while sck high", si_glitch, 0);
         chk(dout == VEC[i][7:0], "R6 captured byte", dout, VEC[i][7:0]);
         chk(si_bad == 0, "R7 si high in data phase", si_bad, 0);
         chk(t_cs_rise - t_cs_fall == 128 * Q * TCLK, "R8 cs low span",
             t_cs_rise - t_cs_fall, 128 * Q * TCLK);
         chk(d_at == 128 * Q + 1 && d_cnt == 1, "R8 done timing and width",
             d_at * 16 + d_cnt, (128 * Q + 1) * 16 + 1);
         chk(gaps == 0 && busy == 1'b0 && cs_n == 1'b1, "R9 busy window",
             {gaps[3:0], busy, cs_n}, 6'b000001);
      end

      // R10: byte held after the read
      held = dout;
      repeat (20) @(negedge clk);
      chk(dout == held, "R10 data held while idle", dout, held);

      // R9: a second start mid-read is ignored
      run_read(16'hC3A9, 8'h96, 40, d_at, d_cnt, gaps);
      chk(shin == {8'h03, 16'hC3A9}, "R9 address unchanged by extra start", shin,
          {8'h03, 16'hC3A9});
      chk(d_cnt == 1 && d_at == 128 * Q + 1, "R9 single done despite extra start",
          d_at * 16 + d_cnt, (128 * Q + 1) * 16 + 1);
      chk(dout == 8'h96, "R6 byte after ignored start", dout, 8'h96);

      // R1: reset in the middle of a read
      resp_byte = 8'h11;
      @(negedge clk); addr = 16'h0101; start = 1'b1;
      @(negedge clk); start = 1'b0;
      repeat (50) @(negedge clk);
      chk(cs_n === 1'b0 && busy === 1'b1, "R9 busy mid read", {cs_n, busy}, 2'b01);
      rst_n = 1'b0;
      @(negedge clk);
      chk(cs_n === 1'b1 && sck === 1'b0 && busy === 1'b0 && done === 1'b0,
          "R1 lines after mid-read reset", {cs_n, sck, busy, done}, 4'b1000);
      rst_n = 1'b1;
      @(negedge clk);

      // recovery read after the aborted one
      run_read(16'h7E81, 8'h5A, 0, d_at, d_cnt, gaps);
      chk(shin == {8'h03, 16'h7E81}, "R2 wire bits after recovery", shin, {8'h03, 16'h7E81});
      chk(dout == 8'h5A, "R6 byte after recovery", dout, 8'h5A);

      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      nchk++;
      nerr++;
      $display("FAIL watchdog actual=expired expected=finished");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end

endmodule